// File: doc/BRIEF.md
# Threshold Stop/Go Receive Buffer

This block sits at the receiving end of one network-on-chip link. The upstream sender marks each flit with a one-cycle enable. The receiver stores flits in a circular store and hands them to a local consumer in arrival order. The consumer side is a valid/ready stream. The only signal that goes back to the sender is a single stop level.

Backpressure uses two levels. The stop level is raised when the stored count climbs to an upper mark. It is dropped only when the count has drained to a lower mark. Inside the band between the two marks the level does not change, so it does not chatter. The upper mark is placed below the store depth by the number of flits that can still land after the decision is taken. That number is the receiver's issue delay, plus the sender's reaction delay, plus two one-way wire delays, all counted in cycles. Depth is counted in flits, so the flit-size factor is one. If the configuration leaves no room for those flits, or leaves the lower mark at or above the upper one, the design refuses to elaborate.

The back-pressure rules on the consumer side are as follows. `out_valid_o` is high whenever at least one flit is stored. A flit leaves on a clock edge where valid and ready are both high. While valid is high and ready is low, the presented flit stays put. Ready may be high while the store is empty; nothing happens in that case.

Top module: `sg_rx_buffer`

## Requirements
- R1: Flits leave on the output stream in the order they were accepted, with none lost or repeated.
- R2: `out_valid_o` is high exactly when the store holds at least one flit. While `out_valid_o` is high and `out_ready_i` is low, `out_data_o` and `out_valid_o` do not change.
- R3: A flit whose `link_en_i` falls on an edge where the store already holds DEPTH flits is discarded. This holds even if a read happens on the same edge. A flit is accepted whenever fewer than DEPTH are held, and reads and writes may occur on the same edge.
- R4: The internal stop flag sets on the edge where the stored count reaches STOP_LVL = DEPTH - (RX_OVH + TX_OVH + 2*LINK_DLY).
- R5: The internal stop flag clears on the edge where the stored count falls to GO_LVL or below.
- R6: While the stored count is strictly between GO_LVL and STOP_LVL, the flag keeps its previous value.
- R7: `stop_o` equals the internal flag delayed by exactly RX_OVH clock edges. A value of 0 means no delay.
- R8: During reset and after its release, the store is empty, `out_valid_o` is low and `stop_o` is low (go).
- R9: Suppose a sender stops launching TX_OVH cycles after it sees `stop_o` high, and both link directions take at most LINK_DLY cycles. Then no flit is ever discarded. With the longest delays and a stalled consumer, the count reaches exactly DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| link_en_i | input | 1 | Flit present on the link this cycle |
| link_flit_i | input | FLIT_W | Flit payload from the link |
| stop_o | output | 1 | Backpressure level to the sender, 1 = stop, 0 = go |
| out_valid_o | output | 1 | A stored flit is presented |
| out_ready_i | input | 1 | Consumer takes the presented flit |
| out_data_o | output | FLIT_W | Oldest stored flit |

## Verification
A corrupted count can show up in two ways. It can move `stop_o` off its marks, and the per-cycle comparison against the behavioural queue catches that RX_OVH cycles after the faulty edge. It can also show up as a wrong `out_valid_o` on the very next cycle. A bad read or write pointer shows up first as a wrong `out_data_o` at the head of the stream, or as a missing or repeated sequence number when the store drains. A sizing fault would let flits be discarded while the sender obeys the protocol, or would fail to reach exactly DEPTH under a stalled consumer. The runs that vary the link delay and the consumer rate expose both.

// File: rtl/sg_pkg.sv
package sg_pkg;

  // Flits that can still land after the receiver decides to stop.
  function automatic int unsigned sg_inflight(input int unsigned rx_ovh,
                                              input int unsigned tx_ovh,
                                              input int unsigned link_dly);
    return rx_ovh + tx_ovh + 2 * link_dly;
  endfunction

  typedef enum logic {
    SG_GO   = 1'b0,
    SG_STOP = 1'b1
  } sg_state_e;

endpackage

// File: rtl/sg_flit_store.sv
module sg_flit_store #(
  parameter int FLIT_W = 16,
  parameter int DEPTH  = 16,
  parameter int AW     = 4,
  parameter int CW     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FLIT_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [FLIT_W-1:0] rd_data,
  output logic [CW-1:0]     occ,
  output logic [CW-1:0]     occ_nxt
);

  logic [FLIT_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     occ_q;
  logic              do_wr, do_rd;

  function automatic logic [AW-1:0] step_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // A full store turns the write away even when a read happens on the same edge.
  assign do_wr = wr_en && (occ_q != CW'(DEPTH));
  assign do_rd = rd_en && (occ_q != '0);

  always_comb begin
    occ_nxt = occ_q + {{(CW-1){1'b0}}, do_wr} - {{(CW-1){1'b0}}, do_rd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
    end else begin
      if (do_wr) wr_ptr <= step_ptr(wr_ptr);
      if (do_rd) rd_ptr <= step_ptr(rd_ptr);
      occ_q <= occ_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];
  assign occ     = occ_q;

endmodule

// File: rtl/sg_hysteresis.sv
module sg_hysteresis
  import sg_pkg::*;
#(
  parameter int CW       = 5,
  parameter int STOP_LVL = 10,
  parameter int GO_LVL   = 4,
  parameter int RX_OVH   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] occ_nxt,
  output logic          flag,
  output logic          stop_o
);

  sg_state_e st_q, st_d;

  // The count moves by at most one per edge, so each mark is met exactly.
  always_comb begin
    st_d = st_q;
    if (occ_nxt >= CW'(STOP_LVL))    st_d = SG_STOP;
    else if (occ_nxt <= CW'(GO_LVL)) st_d = SG_GO;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SG_GO;
    else        st_q <= st_d;
  end

  assign flag = (st_q == SG_STOP);

  // Issue delay on the receiver side before the level leaves the block.
  if (RX_OVH > 0) begin : g_issue_dly
    logic [RX_OVH-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q <= '0;
      end else begin
        pipe_q[0] <= flag;
        for (int i = 1; i < RX_OVH; i++) pipe_q[i] <= pipe_q[i-1];
      end
    end
    assign stop_o = pipe_q[RX_OVH-1];
  end else begin : g_issue_direct
    assign stop_o = flag;
  end

endmodule

// File: rtl/sg_rx_buffer.sv
module sg_rx_buffer
  import sg_pkg::*;
#(
  parameter int FLIT_W   = 16,
  parameter int DEPTH    = 16,
  parameter int LINK_DLY = 2,
  parameter int RX_OVH   = 1,
  parameter int TX_OVH   = 1,
  parameter int GO_LVL   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_en_i,
  input  logic [FLIT_W-1:0] link_flit_i,
  output logic              stop_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [FLIT_W-1:0] out_data_o
);

  localparam int INFLIGHT = int'(sg_inflight(RX_OVH, TX_OVH, LINK_DLY));
  localparam int STOP_LVL = DEPTH - INFLIGHT;
  localparam int AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW       = $clog2(DEPTH + 1);

  if (DEPTH < INFLIGHT + 1 || STOP_LVL <= GO_LVL || GO_LVL < 0) begin : g_bad_cfg
    $error("sg_rx_buffer: depth too small for round trip or marks out of order");
  end

  logic [CW-1:0] occ_w, occ_nxt_w;
  logic          flag_w;

  sg_flit_store #(
    .FLIT_W (FLIT_W),
    .DEPTH  (DEPTH),
    .AW     (AW),
    .CW     (CW)
  ) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (link_en_i),
    .wr_data (link_flit_i),
    .rd_en   (out_ready_i),
    .rd_data (out_data_o),
    .occ     (occ_w),
    .occ_nxt (occ_nxt_w)
  );

  sg_hysteresis #(
    .CW       (CW),
    .STOP_LVL (STOP_LVL),
    .GO_LVL   (GO_LVL),
    .RX_OVH   (RX_OVH)
  ) hyst_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .occ_nxt (occ_nxt_w),
    .flag    (flag_w),
    .stop_o  (stop_o)
  );

  assign out_valid_o = (occ_w != '0);

endmodule

// File: rtl/sg_rx_buffer_chk.sv
module sg_rx_buffer_chk #(
  parameter int FLIT_W   = 16,
  parameter int DEPTH    = 16,
  parameter int STOP_LVL = 10,
  parameter int GO_LVL   = 4,
  parameter int CW       = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              link_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [FLIT_W-1:0] out_data,
  input logic [CW-1:0]     occ,
  input logic              flag
);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_en && occ == CW'(DEPTH) && !out_ready) |=> occ == CW'(DEPTH));

  assert_stop_at_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> occ == CW'(STOP_LVL));

  assert_go_at_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> occ == CW'(GO_LVL));

  assert_band_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (occ > CW'(GO_LVL) && occ < CW'(STOP_LVL)) |-> $stable(flag));

  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind sg_rx_buffer sg_rx_buffer_chk #(
  .FLIT_W   (FLIT_W),
  .DEPTH    (DEPTH),
  .STOP_LVL (STOP_LVL),
  .GO_LVL   (GO_LVL),
  .CW       (CW)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .link_en   (link_en_i),
  .out_valid (out_valid_o),
  .out_ready (out_ready_i),
  .out_data  (out_data_o),
  .occ       (occ_w),
  .flag      (flag_w)
);

// File: tb/sg_rx_buffer_tb_top.sv
module sg_rx_buffer_tb_top;

  localparam int FLIT_W   = 16;
  localparam int DEPTH    = 16;
  localparam int LINK_DLY = 2;
  localparam int RX_OVH   = 1;
  localparam int TX_OVH   = 1;
  localparam int GO_LVL   = 4;
  localparam int INFLIGHT = RX_OVH + TX_OVH + 2 * LINK_DLY;
  localparam int STOP_LVL = DEPTH - INFLIGHT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              link_en = 1'b0;
  logic [FLIT_W-1:0] link_flit = '0;
  logic              out_ready = 1'b0;
  logic              stop_o, out_valid;
  logic [FLIT_W-1:0] out_data;

  sg_rx_buffer #(
    .FLIT_W   (FLIT_W),
    .DEPTH    (DEPTH),
    .LINK_DLY (LINK_DLY),
    .RX_OVH   (RX_OVH),
    .TX_OVH   (TX_OVH),
    .GO_LVL   (GO_LVL)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_en_i   (link_en),
    .link_flit_i (link_flit),
    .stop_o      (stop_o),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_data_o  (out_data)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: a queue, a flag and the flag's history.
  logic [FLIT_W-1:0] mq[$];
  bit m_flag = 1'b0;
  bit m_hist [0:15];
  int m_drops = 0;
  int m_pops = 0;
  int m_max = 0;
  bit tx_phase = 1'b0;
  bit cmp_on = 1'b0;

  always @(posedge clk) begin : model
    int sz;
    bit push, pop;
    if (!rst_n) begin
      mq.delete();
      m_flag = 1'b0;
      for (int i = 0; i < 16; i++) m_hist[i] = 1'b0;
    end else begin
      sz   = mq.size();
      pop  = out_ready && (sz > 0);
      push = link_en && (sz < DEPTH);
      if (link_en && !push && tx_phase) m_drops++;
      if (pop) begin
        void'(mq.pop_front());
        m_pops++;
      end
      if (push) mq.push_back(link_flit);
      sz = mq.size();
      if (sz > m_max) m_max = sz;
      if (sz >= STOP_LVL) m_flag = 1'b1;
      else if (sz <= GO_LVL) m_flag = 1'b0;
      for (int i = 15; i > 0; i--) m_hist[i] = m_hist[i-1];
      m_hist[0] = m_flag;
    end
  end

  // Compare outputs with the reference every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk(out_valid == (mq.size() > 0), "R2", "out_valid", longint'(out_valid),
          longint'(mq.size() > 0));
      if (mq.size() > 0)
        chk(out_data == mq[0], "R1", "head flit", longint'(out_data), longint'(mq[0]));
      chk(stop_o == m_hist[RX_OVH], "R7", "stop level", longint'(stop_o),
          longint'(m_hist[RX_OVH]));
    end
  end

  task automatic step(input bit en, input logic [FLIT_W-1:0] d, input bit rdy);
    @(negedge clk);
    link_en   = en;
    link_flit = d;
    out_ready = rdy;
  endtask

  int seq = 0;

  // Sender model: launches unless it saw stop TX_OVH cycles after it crossed the link.
  task automatic run_tx(input int dly, input int mode, input int nflits);
    bit                st_rec [0:63];
    bit                sv     [0:63];
    logic [FLIT_W-1:0] sd     [0:63];
    int sent, pops0, seen_idx, first;
    bit seen;
    for (int i = 0; i < 64; i++) begin
      st_rec[i] = 1'b0;
      sv[i] = 1'b0;
      sd[i] = '0;
    end
    sent = 0;
    pops0 = m_pops;
    first = seq;
    m_drops = 0;
    m_max = 0;
    tx_phase = 1'b1;
    for (int c = 0; c < 1500; c++) begin
      @(negedge clk);
      st_rec[c % 64] = stop_o;
      seen = 1'b0;
      if (c >= dly + TX_OVH) begin
        seen_idx = (c - dly - TX_OVH) % 64;
        seen = st_rec[seen_idx];
      end
      if (!seen && sent < nflits) begin
        sv[(c + dly) % 64] = 1'b1;
        sd[(c + dly) % 64] = FLIT_W'(seq);
        seq++;
        sent++;
      end
      link_en   = sv[c % 64];
      link_flit = sd[c % 64];
      sv[c % 64] = 1'b0;
      case (mode)
        0:       out_ready = 1'b1;
        1:       out_ready = ($urandom % 2) == 1;
        2:       out_ready = ($urandom % 4) == 0;
        default: out_ready = (c >= 300);
      endcase
    end
    for (int c = 0; c < 40; c++) step(1'b0, '0, 1'b1);
    chk(sent == nflits, "R9", "flits launched", longint'(sent), longint'(nflits));
    chk(m_pops - pops0 == nflits, "R1", "flits delivered", longint'(m_pops - pops0),
        longint'(nflits));
    chk(m_drops == 0, "R9", "flits discarded under protocol", longint'(m_drops), 0);
    chk(!out_valid, "R1", "drained after run", longint'(out_valid), 0);
    if (mode == 3 && dly == LINK_DLY)
      chk(m_max == DEPTH, "R9", "peak count with stalled consumer", longint'(m_max),
          longint'(DEPTH));
    if (first < 0) $display("unreachable");
    tx_phase = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(!out_valid, "R8", "valid in reset", longint'(out_valid), 0);
    chk(!stop_o, "R8", "stop in reset", longint'(stop_o), 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    step(1'b0, '0, 1'b0);
    step(1'b0, '0, 1'b0);
    chk(!out_valid, "R8", "valid after reset", longint'(out_valid), 0);
    chk(!stop_o, "R8", "stop after reset", longint'(stop_o), 0);

    // Directed fill with the consumer stalled.
    for (int i = 0; i < STOP_LVL - 1; i++) step(1'b1, FLIT_W'(16'hA000 + i), 1'b0);
    repeat (RX_OVH + 2) step(1'b0, '0, 1'b0);
    chk(!stop_o, "R4", "stop one below mark", longint'(stop_o), 0);
    step(1'b1, FLIT_W'(16'hA000 + STOP_LVL - 1), 1'b0);
    repeat (RX_OVH) step(1'b0, '0, 1'b0);
    if (RX_OVH > 0) chk(!stop_o, "R7", "stop before issue delay", longint'(stop_o), 0);
    step(1'b0, '0, 1'b0);
    chk(stop_o, "R4", "stop at mark", longint'(stop_o), 1);
    for (int i = STOP_LVL; i < DEPTH; i++) step(1'b1, FLIT_W'(16'hA000 + i), 1'b0);
    step(1'b1, FLIT_W'(16'hBAD0), 1'b0);
    step(1'b1, FLIT_W'(16'hBAD1), 1'b0);
    step(1'b0, '0, 1'b0);

    // Drain one flit at a time, watching the lower mark.
    for (int k = 0; k < DEPTH; k++) begin
      chk(out_valid, "R3", "stored flit present", longint'(out_valid), 1);
      chk(out_data == FLIT_W'(16'hA000 + k), "R3", "no full-store write kept",
          longint'(out_data), longint'(16'hA000 + k));
      step(1'b0, '0, 1'b1);
      step(1'b0, '0, 1'b0);
      if (DEPTH - k - 1 == GO_LVL + 1) begin
        repeat (RX_OVH + 1) step(1'b0, '0, 1'b0);
        chk(stop_o, "R6", "stop held inside band", longint'(stop_o), 1);
      end
      if (DEPTH - k - 1 == GO_LVL) begin
        repeat (RX_OVH + 1) step(1'b0, '0, 1'b0);
        chk(!stop_o, "R5", "go at lower mark", longint'(stop_o), 0);
      end
    end
    chk(!out_valid, "R3", "empty after DEPTH flits", longint'(out_valid), 0);

    // Protocol-following sender at several delays and consumer rates.
    run_tx(LINK_DLY, 0, 200);
    run_tx(LINK_DLY, 1, 200);
    run_tx(1, 2, 150);
    run_tx(0, 1, 200);
    run_tx(LINK_DLY, 3, 200);
    run_tx(1, 3, 100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule